// File: doc/BRIEF.md
# Descriptor Ring Producer with Lap Stamping

This block owns a circular ring of fixed-size descriptors kept in internal storage. An upstream producer hands it one whole descriptor per accepted transfer; the block writes it into the slot at the head pointer, overwrites the top twelve bits of the descriptor's last 32-bit word with a 4-bit lap value and an 8-bit ring identifier, and advances the head. The lap value is derived from an internal lap counter that starts at zero and steps each time the head wraps from the last slot back to slot 0, so every entry written during a pass carries the pass number plus one, modulo 16.

A consumer reads the entry at the tail pointer through a combinational read port and retires it with a pop strobe. Instead of comparing pointers, the consumer can decide whether the tail slot holds a fresh entry by checking only the lowest bit of its lap field against an expected parity that starts at one and toggles whenever the tail wraps. The ring keeps one slot empty to tell full from empty, and refuses writes while full.

Top module: `desc_ring_prod`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, head_o, tail_o and lap_o are 0, push_ready_o is 0 and rd_fresh_o is 0.
- R2: An accepted push (push_valid_i and push_ready_o high at a clock edge) stores the descriptor in the head slot; words 0 to WORDS-2 and bits 19:0 of word WORDS-1 reach rd_desc_o unchanged, and entries leave in the order they were accepted.
- R3: Bits 31:28 of word WORDS-1 of every stored entry hold lap_o+1 modulo 16, with lap_o taken at the cycle the push is accepted.
- R4: Bits 27:20 of word WORDS-1 of every stored entry hold the value of ring_id_i sampled on the first clock edge after reset release; later changes of ring_id_i have no effect on stored entries.
- R5: lap_o increments by one, wrapping from 15 to 0, on each accepted push made while head_o equals DEPTH-1; it is unchanged otherwise.
- R6: The ring is full when head_o+1 equals tail_o modulo DEPTH; then push_ready_o is 0, a push attempt is refused and head_o does not move.
- R7: pop_i advances tail_o by one (wrapping at DEPTH) when the ring is not empty; a pop on an empty ring (head_o equal to tail_o) leaves tail_o unchanged.
- R8: rd_fresh_o is 1 exactly when bit 28 of word WORDS-1 at the tail slot equals an expected parity that is 1 after reset and toggles on each tail wrap; as a result rd_fresh_o is 1 exactly when the ring is not empty.
- R9: Across the lap counter wrap, entries stamped with lap value 0 on the sixteenth pass are still reported fresh, and stale slots left from the previous pass are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_id_i | input | 8 | Static ring identifier, sampled once after reset release |
| push_valid_i | input | 1 | Producer offers a descriptor |
| push_desc_i | input | WORDS*32 | Descriptor, word 0 in the low bits |
| push_ready_o | output | 1 | Ring can accept a descriptor this cycle |
| pop_i | input | 1 | Consumer retires the tail entry |
| rd_desc_o | output | WORDS*32 | Entry stored at the tail slot |
| rd_fresh_o | output | 1 | Tail entry lap parity matches the expected parity |
| head_o | output | log2(DEPTH) | Write slot index |
| tail_o | output | log2(DEPTH) | Read slot index |
| lap_o | output | 4 | Producer lap counter |

## Verification
The bench drives the ring into the full state and attempts one more push, since a design using all DEPTH slots would overwrite the oldest unread entry and make full look like empty. It pops an empty ring to catch a tail that runs past the head and a parity that toggles on a refused pop. A long random phase carries the head through far more than sixteen passes, so a lap counter that saturates, stamps the counter itself instead of counter plus one, or a parity that tracks the wrong pointer shows up as a wrong lap field or a fresh flag that disagrees with occupancy. The ring identifier input is changed after its sampling edge to expose a design that stamps the live input.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LAP_W   = 4;
  localparam int unsigned ID_W    = 8;
  localparam int unsigned LAP_LSB = 28;
  localparam int unsigned ID_LSB  = 20;

  typedef logic [LAP_W-1:0] lap_t;
  typedef logic [ID_W-1:0]  ring_id_t;
endpackage

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  output logic [$clog2(DEPTH)-1:0] ptr_o,
  output logic                     wrap_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q;

  assign wrap_o = adv_i && (ptr_q == LAST);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (wrap_o) ptr_q <= '0;
    else if (adv_i)  ptr_q <= ptr_q + IDX_W'(1);
  end
endmodule

// File: rtl/desc_ring_store.sv
module desc_ring_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DESC_W = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DESC_W-1:0]        wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DESC_W-1:0]        rdata_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DESC_W-1:0] slot_q [DEPTH];

  // slots reset to zero so stale lap parity is defined before the first pass
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[s] <= '0;
      else if (we_i && (waddr_i == IDX_W'(s)))     slot_q[s] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/desc_lap_stamper.sv
module desc_lap_stamper
  import desc_ring_pkg::*;
#(
  parameter int unsigned WORDS = 8
) (
  input  logic [WORDS*WORD_W-1:0] desc_i,
  input  lap_t                    lap_i,
  input  ring_id_t                id_i,
  output logic [WORDS*WORD_W-1:0] desc_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == WORDS - 1) begin : g_last
      assign desc_o[w*WORD_W +: WORD_W] = {lap_i, id_i, desc_i[w*WORD_W +: ID_LSB]};
    end else begin : g_pass
      assign desc_o[w*WORD_W +: WORD_W] = desc_i[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/desc_ring_prod.sv
module desc_ring_prod
  import desc_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WORDS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [7:0]                ring_id_i,
  input  logic                      push_valid_i,
  input  logic [WORDS*32-1:0]       push_desc_i,
  output logic                      push_ready_o,
  input  logic                      pop_i,
  output logic [WORDS*32-1:0]       rd_desc_o,
  output logic                      rd_fresh_o,
  output logic [$clog2(DEPTH)-1:0]  head_o,
  output logic [$clog2(DEPTH)-1:0]  tail_o,
  output logic [3:0]                lap_o
);
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam int unsigned DESC_W  = WORDS * WORD_W;
  localparam int unsigned PAR_BIT = (WORDS - 1) * WORD_W + LAP_LSB;

  logic             id_loaded_q;
  ring_id_t         ring_id_q;
  lap_t             lap_q;
  logic             par_q;
  logic [IDX_W-1:0] head, tail;
  logic             head_wrap, tail_wrap;
  logic             full, empty, push_fire, pop_fire;
  logic [DESC_W-1:0] stamped;

  assign empty        = (head == tail);
  assign full         = ((head + IDX_W'(1)) == tail);
  assign push_ready_o = id_loaded_q && !full;
  assign push_fire    = push_valid_i && push_ready_o;
  assign pop_fire     = pop_i && !empty;

  // ring id latched once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_loaded_q <= 1'b0;
      ring_id_q   <= '0;
    end else if (!id_loaded_q) begin
      id_loaded_q <= 1'b1;
      ring_id_q   <= ring_id_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lap_q <= '0;
    else if (head_wrap) lap_q <= lap_q + lap_t'(1);
  end

  // consumer parity: first pass is stamped 1, so expect odd first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        par_q <= 1'b1;
    else if (tail_wrap) par_q <= ~par_q;
  end

  desc_ring_ptr #(.DEPTH(DEPTH)) i_head (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (push_fire),
    .ptr_o  (head),
    .wrap_o (head_wrap)
  );

  desc_ring_ptr #(.DEPTH(DEPTH)) i_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pop_fire),
    .ptr_o  (tail),
    .wrap_o (tail_wrap)
  );

  desc_lap_stamper #(.WORDS(WORDS)) i_stamp (
    .desc_i (push_desc_i),
    .lap_i  (lap_q + lap_t'(1)),
    .id_i   (ring_id_q),
    .desc_o (stamped)
  );

  desc_ring_store #(.DEPTH(DEPTH), .DESC_W(DESC_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push_fire),
    .waddr_i (head),
    .wdata_i (stamped),
    .raddr_i (tail),
    .rdata_o (rd_desc_o)
  );

  assign rd_fresh_o = (rd_desc_o[PAR_BIT] == par_q);
  assign head_o     = head;
  assign tail_o     = tail;
  assign lap_o      = lap_q;
endmodule

// File: rtl/desc_ring_prod_chk.sv
module desc_ring_prod_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     push_valid_i,
  input logic                     push_ready_o,
  input logic                     pop_i,
  input logic                     rd_fresh_o,
  input logic [$clog2(DEPTH)-1:0] head_o,
  input logic [$clog2(DEPTH)-1:0] tail_o,
  input logic [3:0]               lap_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic acc;
  assign acc = push_valid_i && push_ready_o;

  a_r6_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((head_o + IDX_W'(1)) == tail_o) |-> !push_ready_o);

  a_r6_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(head_o));

  a_r2_head_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (head_o == $past(head_o) + IDX_W'(1)));

  a_r7_empty_pop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o == tail_o) |=> $stable(tail_o));

  a_r5_lap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && head_o == LAST) |=> (lap_o == $past(lap_o) + 4'd1));

  a_r5_lap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && head_o == LAST) |=> $stable(lap_o));

  a_r8_fresh_iff_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fresh_o == (head_o != tail_o));

  a_r7_tail_moves_on_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && head_o != tail_o) |=> (tail_o == $past(tail_o) + IDX_W'(1)));
endmodule

bind desc_ring_prod desc_ring_prod_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_valid_i (push_valid_i),
  .push_ready_o (push_ready_o),
  .pop_i        (pop_i),
  .rd_fresh_o   (rd_fresh_o),
  .head_o       (head_o),
  .tail_o       (tail_o),
  .lap_o        (lap_o)
);

// File: tb/test_desc_ring_prod.sv
`timescale 1ns/1ps
module test_desc_ring_prod;
  localparam int DEPTH = 16;
  localparam int WORDS = 8;
  localparam int DW    = WORDS * 32;
  localparam int IW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    ring_id_i = 8'hA5;
  logic          push_valid_i = 1'b0;
  logic [DW-1:0] push_desc_i = '0;
  logic          push_ready_o;
  logic          pop_i = 1'b0;
  logic [DW-1:0] rd_desc_o;
  logic          rd_fresh_o;
  logic [IW-1:0] head_o, tail_o;
  logic [3:0]    lap_o;

  always #10 clk = ~clk;

  desc_ring_prod #(.DEPTH(DEPTH), .WORDS(WORDS)) i_desc_ring_prod (
    .clk_i(clk), .rst_ni(rst_ni), .ring_id_i(ring_id_i),
    .push_valid_i(push_valid_i), .push_desc_i(push_desc_i), .push_ready_o(push_ready_o),
    .pop_i(pop_i), .rd_desc_o(rd_desc_o), .rd_fresh_o(rd_fresh_o),
    .head_o(head_o), .tail_o(tail_o), .lap_o(lap_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [DW-1:0] q[$];
  int   m_head = 0, m_tail = 0, m_lap = 0;
  bit   m_loaded = 0;
  logic [7:0] m_id = '0;

  function automatic logic [DW-1:0] stamp(logic [DW-1:0] d, int lap, logic [7:0] id);
    logic [DW-1:0] r = d;
    r[DW-1 -: 4]   = 4'((lap + 1) % 16);
    r[DW-5 -: 8]   = id;
    return r;
  endfunction

  function automatic logic [DW-1:0] rand_desc();
    logic [DW-1:0] d;
    for (int w = 0; w < WORDS; w++) d[w*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic check_outputs();
    bit exp_ready = m_loaded && (q.size() < DEPTH - 1);
    chk(head_o == IW'(m_head), "R2 head", DW'(head_o), DW'(m_head));
    chk(tail_o == IW'(m_tail), "R7 tail", DW'(tail_o), DW'(m_tail));
    chk(lap_o == 4'(m_lap), "R5 lap", DW'(lap_o), DW'(m_lap));
    chk(push_ready_o == exp_ready, "R6 ready", DW'(push_ready_o), DW'(exp_ready));
    chk(rd_fresh_o == (q.size() > 0), "R8 fresh", DW'(rd_fresh_o), DW'(q.size() > 0));
    if (q.size() > 0) begin
      chk(rd_desc_o == q[0], "R2 entry", rd_desc_o, q[0]);
      chk(rd_desc_o[DW-1 -: 4] == q[0][DW-1 -: 4], "R3 lap field",
          DW'(rd_desc_o[DW-1 -: 4]), DW'(q[0][DW-1 -: 4]));
      chk(rd_desc_o[DW-5 -: 8] == m_id, "R4 id field",
          DW'(rd_desc_o[DW-5 -: 8]), DW'(m_id));
      if (q[0][DW-1 -: 4] == 4'd0)
        chk(rd_fresh_o == 1'b1, "R9 lap-0 entry fresh", DW'(rd_fresh_o), DW'(1));
    end
  endtask

  // check at negedge, drive, advance one edge, update model, return at negedge
  task automatic step(input bit pv, input logic [DW-1:0] d, input bit pp);
    bit acc_push, acc_pop;
    check_outputs();
    acc_push = pv && m_loaded && (q.size() < DEPTH - 1);
    acc_pop  = pp && (q.size() > 0);
    push_valid_i = pv; push_desc_i = d; pop_i = pp;
    @(posedge clk);
    if (!m_loaded) begin m_loaded = 1; m_id = ring_id_i; end
    if (acc_pop) begin
      void'(q.pop_front());
      m_tail = (m_tail + 1) % DEPTH;
    end
    if (acc_push) begin
      q.push_back(stamp(d, m_lap, m_id));
      if (m_head == DEPTH - 1) m_lap = (m_lap + 1) % 16;
      m_head = (m_head + 1) % DEPTH;
    end
    @(negedge clk);
    push_valid_i = 1'b0; pop_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all: watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int head_before;
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(head_o == 0 && tail_o == 0, "R1 pointers", DW'({head_o, tail_o}), DW'(0));
    chk(lap_o == 0, "R1 lap", DW'(lap_o), DW'(0));
    chk(push_ready_o == 0, "R1 ready", DW'(push_ready_o), DW'(0));
    chk(rd_fresh_o == 0, "R1 fresh", DW'(rd_fresh_o), DW'(0));
    rst_ni = 1'b1;
    chk(push_ready_o == 0, "R1 ready before id load", DW'(push_ready_o), DW'(0));
    step(0, '0, 0);            // id sampled on this edge
    ring_id_i = 8'h3C;         // R4: later change must be ignored

    // R7: pop on empty ring
    step(0, '0, 1);
    // R6: fill to DEPTH-1 then attempt one more
    for (int i = 0; i < DEPTH - 1; i++) step(1, rand_desc(), 0);
    head_before = m_head;
    step(1, rand_desc(), 0);
    chk(head_o == IW'(head_before), "R6 refused push holds head", DW'(head_o), DW'(head_before));
    // drain, then empty pop again
    for (int i = 0; i < DEPTH - 1; i++) step(0, '0, 1);
    step(0, '0, 1);
    // simultaneous push and pop
    for (int i = 0; i < 20; i++) step(1, rand_desc(), i > 0);

    // random phase: many laps, crosses the 15->0 lap wrap repeatedly
    for (int i = 0; i < 4000; i++) begin
      bit pv = ($urandom % 100) < 60;
      bit pp = ($urandom % 100) < 50;
      step(pv, rand_desc(), pp);
    end
    chk(m_lap != 0 || m_head != 0, "R9 laps advanced", DW'(m_lap), DW'(m_lap));
    check_outputs();
    done = 1;
    summary();
    $finish;
  end
endmodule